// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing controller of a 4096-byte serial EEPROM that sits on a two-wire clock/data bus as a slave. Its clock and data inputs have already been brought into the system clock domain. The engine watches them for start and stop conditions. It checks the device-type byte that opens each transaction and loads a 12-bit word pointer from two address bytes. It then serves writes of single bytes or pages, and reads at the current pointer, at a random address, or in sequence.

The engine writes nothing to the array itself. Each accepted data byte goes out on a write strobe with its address, and a commit pulse after the stop condition tells an external page-write sequencer to begin programming. While that sequencer reports busy, the engine acknowledges nothing at all, so a master can poll for completion. Reads come from an array read port addressed by the internal pointer. The engine drives the data line only through an open-drain pull-down enable, and it changes that enable only a few system clocks after a falling bus-clock edge.

Top module: `eeprom_twi_slave`

## Requirements
- R1: A start is data falling while clock is high and a stop is data rising while clock is high. Bytes clocked in without a preceding start are ignored and get no acknowledge.
- R2: A first byte of the form 1010 000x (bit 0 = 1 for read, 0 for write) is acknowledged. Any other first byte gets no acknowledge, and later bytes are ignored until the next start.
- R3: After a write-type first byte, the engine takes the high address byte and then the low byte, MSB first. A high byte whose upper four bits are not zero is not acknowledged, the transaction is dropped, and the pointer is unchanged.
- R4: Each acknowledged data byte is presented as a one-cycle wr_en pulse with wr_addr and wr_data. wr_commit pulses for one cycle after a stop that ends a transaction in which data was accepted.
- R5: Within a write, the pointer advances only in its low 5 bits, so a page write wraps within its 32-byte page (0x03F is followed by 0x020).
- R6: While wr_busy is high, no byte is acknowledged, the first byte included. Once wr_busy falls, a polling first byte is acknowledged.
- R7: A current-address read returns the byte at the address after the last one accessed, whether by read or by write.
- R8: A random read sets the pointer with a write-type header and two address bytes. A repeated start and a read-type first byte then return the byte at that address, and no write strobe or commit results.
- R9: In a read, a master acknowledge brings the next byte. The pointer wraps from 0xFFF to 0x000. After a master non-acknowledge the data line is left released.
- R10: sda_oe changes only while the bus clock is low, and no sooner than HOLD system clocks after the falling clock edge.
- R11: A start or stop seen in the middle of a byte abandons the transaction. A write aborted by a repeated start is not committed, and the next transaction begins from a fresh bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_raddr | output | 12 | Array read address (current pointer) |
| mem_rdata | input | 8 | Array read data for mem_raddr |
| wr_busy | input | 1 | Page-write sequencer is programming |
| wr_en | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr | output | 12 | Address of the strobed byte |
| wr_data | output | 8 | Value of the strobed byte |
| wr_commit | output | 1 | One-cycle pulse: start programming the collected bytes |

## Verification
On every cycle, the assertions check that the pull-down enable moves only while the clock is low. They also check that write strobes are single-cycle pulses issued in the clock-low phase, that a commit follows a bus state with both lines high, and that a strobe and a commit never coincide. The directed scenarios are needed for the rest: the address a read returns after writes, page wrap and array wrap, and acknowledge suppression under busy. The same holds for dropped transactions after a bad header or a bad high address, and for the loss of a write that a repeated start cuts off.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam logic [2:0] DEV_SEL  = 3'b000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic hdr_match(input logic [7:0] b);
        return (b[7:4] == DEV_CODE) && (b[3:1] == DEV_SEL);
    endfunction

endpackage

// File: rtl/twi_bus_cond.sv
module twi_bus_cond
    import twi_ee_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.start = scl_q & scl & sda_q & ~sda;
        ev.stop  = scl_q & scl & ~sda_q & sda;
        ev.rise  = scl & ~scl_q;
        ev.fall  = ~scl & scl_q;
    end
endmodule

// File: rtl/twi_sda_drv.sv
module twi_sda_drv #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic val,
    output logic oe
);
    localparam int CW = $clog2(HOLD + 1);

    logic          pending;
    logic          pend_v;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe      <= 1'b0;
            pending <= 1'b0;
            pend_v  <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            pending <= 1'b1;
            pend_v  <= val;
            cnt     <= CW'(HOLD - 1);
        end else if (pending) begin
            if (cnt == '0) begin
                oe      <= pend_v;
                pending <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
    import twi_ee_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5,
    parameter int HOLD   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    input  logic              wr_busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int HI_W = ADDR_W - 8;

    bus_ev_t           ev;
    eng_state_t        state;
    logic [3:0]        cnt;
    logic              ack_ph;
    logic              acked;
    logic              rd_req;
    logic              mack;
    logic              wrote;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [HI_W-1:0]   hi;
    logic [ADDR_W-1:0] ptr;
    logic              drv_load;
    logic              drv_val;
    logic              byte_ok;

    twi_bus_cond u_cond (
        .clk (clk),
        .rst (rst),
        .scl (scl_i),
        .sda (sda_i),
        .ev  (ev)
    );

    twi_sda_drv #(.HOLD(HOLD)) u_drv (
        .clk  (clk),
        .rst  (rst),
        .load (drv_load),
        .val  (drv_val),
        .oe   (sda_oe)
    );

    assign mem_raddr = ptr;

    // acknowledge decision for the byte just completed
    always_comb begin
        case (state)
            ST_HDR:  byte_ok = hdr_match(shreg) && !wr_busy;
            ST_AHI:  byte_ok = (shreg[7:HI_W] == '0) && !wr_busy;
            ST_ALO:  byte_ok = !wr_busy;
            ST_WDAT: byte_ok = !wr_busy;
            default: byte_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ack_ph    <= 1'b0;
            acked     <= 1'b0;
            rd_req    <= 1'b0;
            mack      <= 1'b0;
            wrote     <= 1'b0;
            shreg     <= '0;
            tx        <= '0;
            hi        <= '0;
            ptr       <= '0;
            drv_load  <= 1'b0;
            drv_val   <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            wr_commit <= 1'b0;
            drv_load  <= 1'b0;
            if (ev.stop) begin
                state     <= ST_IDLE;
                cnt       <= '0;
                ack_ph    <= 1'b0;
                drv_load  <= 1'b1;
                drv_val   <= 1'b0;
                wr_commit <= wrote;
                wrote     <= 1'b0;
            end else if (ev.start) begin
                state    <= ST_HDR;
                cnt      <= '0;
                ack_ph   <= 1'b0;
                drv_load <= 1'b1;
                drv_val  <= 1'b0;
                wrote    <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (ev.rise) begin
                    if (ack_ph) begin
                        mack <= ~sda_i;
                    end else if (cnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda_i};
                        cnt   <= cnt + 1'b1;
                    end
                end else if (ev.fall) begin
                    if (!ack_ph && cnt == 4'd8) begin
                        // end of eighth bit: enter acknowledge clock
                        ack_ph   <= 1'b1;
                        drv_load <= 1'b1;
                        if (state == ST_RDAT) begin
                            drv_val <= 1'b0;
                            acked   <= 1'b1;
                            mack    <= 1'b0;
                            ptr     <= ptr + 1'b1;
                        end else begin
                            drv_val <= byte_ok;
                            acked   <= byte_ok;
                        end
                        if (state == ST_HDR) rd_req <= shreg[0];
                        if (state == ST_AHI) hi <= shreg[HI_W-1:0];
                        if (state == ST_ALO && byte_ok) ptr <= {hi, shreg};
                        if (state == ST_WDAT && byte_ok) begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr;
                            wr_data <= shreg;
                            wrote   <= 1'b1;
                            ptr     <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                        end
                    end else if (ack_ph) begin
                        // end of acknowledge clock
                        ack_ph   <= 1'b0;
                        cnt      <= '0;
                        drv_load <= 1'b1;
                        drv_val  <= 1'b0;
                        if (!acked) begin
                            state <= ST_IDLE;
                        end else begin
                            case (state)
                                ST_HDR: begin
                                    if (rd_req) begin
                                        state   <= ST_RDAT;
                                        tx      <= mem_rdata;
                                        drv_val <= ~mem_rdata[7];
                                    end else begin
                                        state <= ST_AHI;
                                    end
                                end
                                ST_AHI:  state <= ST_ALO;
                                ST_ALO:  state <= ST_WDAT;
                                ST_RDAT: begin
                                    if (mack) begin
                                        tx      <= mem_rdata;
                                        drv_val <= ~mem_rdata[7];
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                default: state <= state;
                            endcase
                        end
                    end else if (state == ST_RDAT && cnt != 4'd0) begin
                        drv_load <= 1'b1;
                        drv_val  <= ~tx[6];
                        tx       <= {tx[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_twi_slave_chk.sv
module eeprom_twi_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_i,
    input logic sda_oe,
    input logic wr_en,
    input logic wr_commit
);
    // R10
    oe_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R4
    commit_after_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> ($past(scl_i) && $past(sda_i)));

    // R4
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R4
    wr_commit_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_commit));

    // R10
    wr_in_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !scl_i);
endmodule

bind eeprom_twi_slave eeprom_twi_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_commit (wr_commit)
);

// File: tb/eeprom_twi_slave_test.sv
module eeprom_twi_slave_test;
    localparam int Q    = 10;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy = 1'b0;
    logic        sda_oe;
    logic [11:0] mem_raddr;
    logic [7:0]  mem_rdata;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_commit;
    logic        sda_line;

    function automatic logic [7:0] arr(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = arr(mem_raddr);

    eeprom_twi_slave #(.HOLD(HOLD)) uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .wr_busy   (busy),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wcnt  = 0;
    int ccnt  = 0;
    int viol  = 0;
    int since = 0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    logic [11:0] wa [0:63];
    logic [7:0]  wd [0:63];

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_en && wcnt < 64) begin
                wa[wcnt] <= wr_addr;
                wd[wcnt] <= wr_data;
                wcnt     <= wcnt + 1;
            end
            if (wr_commit) ccnt <= ccnt + 1;
            if (sda_oe != oe_prev && (scl || since < HOLD)) viol <= viol + 1;
            since    <= (scl_prev && !scl) ? 0 : since + 1;
            oe_prev  <= sda_oe;
            scl_prev <= scl;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl   = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl   = 1'b1; tick(2 * Q);
            scl   = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        ack   = !sda_line; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            d[i] = sda_line; tick(Q);
            scl = 1'b0; tick(Q);
        end
        sda_m = !give_ack; tick(Q);
        scl   = 1'b1; tick(2 * Q);
        scl   = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [11:0] a, input string req);
        logic k;
        bus_start;
        send_byte(8'hA0, k); chk({req, " header ack"}, k, 1);
        send_byte({4'h0, a[11:8]}, k); chk({req, " addr hi ack"}, k, 1);
        send_byte(a[7:0], k); chk({req, " addr lo ack"}, k, 1);
    endtask

    task automatic cur_read(input logic [11:0] exp_a, input string req);
        logic k;
        logic [7:0] d;
        bus_start;
        send_byte(8'hA1, k); chk({req, " read header ack"}, k, 1);
        recv_byte(1'b0, d);  chk({req, " current read data"}, d, arr(exp_a));
        bus_stop;
    endtask

    task automatic t_reset;
        chk("R10 reset sda_oe", sda_oe, 0);
        chk("R4 reset wr_en", wr_en, 0);
        chk("R4 reset wr_commit", wr_commit, 0);
        chk("R7 reset pointer", mem_raddr, 12'h000);
    endtask

    task automatic t_no_start;
        logic k;
        scl = 1'b0; tick(Q);
        send_byte(8'hA0, k); chk("R1 byte without start", k, 0);
        bus_stop;
    endtask

    task automatic t_bad_hdr;
        logic k;
        bus_start;
        send_byte(8'hA2, k); chk("R2 select bits nonzero", k, 0);
        send_byte(8'h00, k); chk("R2 later byte ignored", k, 0);
        bus_stop;
        bus_start;
        send_byte(8'hB0, k); chk("R2 wrong device code", k, 0);
        bus_stop;
    endtask

    task automatic t_byte_write;
        logic k;
        int w0 = wcnt;
        int c0 = ccnt;
        set_ptr(12'h123, "R4");
        send_byte(8'h5A, k); chk("R4 data ack", k, 1);
        bus_stop; tick(2);
        chk("R4 strobe count", wcnt - w0, 1);
        chk("R4 strobe addr", wa[w0], 12'h123);
        chk("R4 strobe data", wd[w0], 8'h5A);
        chk("R4 commit after stop", ccnt - c0, 1);
    endtask

    task automatic t_page_wrap;
        logic k;
        int w0 = wcnt;
        set_ptr(12'h03E, "R5");
        for (int i = 0; i < 4; i++) begin
            send_byte(8'h10 + 8'(i), k); chk("R5 page data ack", k, 1);
        end
        bus_stop; tick(2);
        chk("R5 addr 0", wa[w0], 12'h03E);
        chk("R5 addr 1", wa[w0 + 1], 12'h03F);
        chk("R5 wrap to page start", wa[w0 + 2], 12'h020);
        chk("R5 addr 3", wa[w0 + 3], 12'h021);
        chk("R5 data 3", wd[w0 + 3], 8'h13);
    endtask

    task automatic t_busy;
        logic k;
        busy = 1'b1;
        bus_start;
        send_byte(8'hA0, k); chk("R6 write header while busy", k, 0);
        bus_stop;
        bus_start;
        send_byte(8'hA1, k); chk("R6 read header while busy", k, 0);
        bus_stop;
        busy = 1'b0;
        bus_start;
        send_byte(8'hA0, k); chk("R6 poll after busy", k, 1);
        bus_stop;
    endtask

    task automatic t_rand_read;
        logic k;
        logic [7:0] d;
        int w0 = wcnt;
        int c0 = ccnt;
        set_ptr(12'hABC, "R8");
        bus_start;
        send_byte(8'hA1, k); chk("R8 read header ack", k, 1);
        recv_byte(1'b0, d);  chk("R8 random data", d, arr(12'hABC));
        bus_stop; tick(2);
        chk("R8 no write strobe", wcnt - w0, 0);
        chk("R8 no commit", ccnt - c0, 0);
    endtask

    task automatic t_seq_wrap;
        logic k;
        logic [7:0] d;
        set_ptr(12'hFFE, "R9");
        bus_start;
        send_byte(8'hA1, k); chk("R9 read header ack", k, 1);
        recv_byte(1'b1, d);  chk("R9 byte FFE", d, arr(12'hFFE));
        recv_byte(1'b1, d);  chk("R9 byte FFF", d, arr(12'hFFF));
        recv_byte(1'b0, d);  chk("R9 wrap to 000", d, arr(12'h000));
        tick(Q);
        chk("R9 released after nack", sda_line, 1);
        bus_stop;
    endtask

    task automatic t_bad_hi;
        logic k;
        bus_start;
        send_byte(8'hA0, k); chk("R3 header ack", k, 1);
        send_byte(8'h10, k); chk("R3 high nibble nonzero", k, 0);
        send_byte(8'h22, k); chk("R3 dropped after bad hi", k, 0);
        bus_stop;
        cur_read(12'h001, "R3");
    endtask

    task automatic t_abort;
        logic k;
        logic [7:0] d;
        int w0;
        int c0;
        bus_start;
        send_byte(8'hA0, k);
        send_byte(8'h04, k);
        send_bits(8'hFF, 3);
        bus_start;
        send_byte(8'hA1, k); chk("R11 header after restart", k, 1);
        recv_byte(1'b0, d);  chk("R11 pointer kept", d, arr(12'h002));
        bus_stop;
        bus_start;
        send_bits(8'hA0, 2);
        bus_stop;
        cur_read(12'h003, "R11");
        w0 = wcnt;
        c0 = ccnt;
        set_ptr(12'h050, "R11");
        send_byte(8'h77, k); chk("R11 data ack", k, 1);
        bus_start;
        bus_stop; tick(2);
        chk("R11 strobe seen", wcnt - w0, 1);
        chk("R11 strobe data", wd[w0], 8'h77);
        chk("R11 aborted write not committed", ccnt - c0, 0);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        finish_run;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        t_reset;
        t_no_start;
        t_bad_hdr;
        t_byte_write;
        cur_read(12'h124, "R7");
        t_page_wrap;
        t_busy;
        cur_read(12'h022, "R7");
        t_rand_read;
        t_seq_wrap;
        t_bad_hi;
        t_abort;
        chk("R10 sda_oe timing violations", viol, 0);
        finish_run;
    end
endmodule